// File: doc/BRIEF.md
# Selectable-Rate Up/Down Step Counter

This block holds an 8-bit count that moves by one step at a time. The steps come at a rate chosen at run time from four fixed periods. A 2-bit rate select picks one of four delay constants, which are parameters of the top module. A free-running tick counter is compared against the chosen constant. When the two match, the block raises a one-cycle step pulse and restarts the tick counter, so pulses recur at a fixed spacing. Each step pulse moves the count up or down, depending on a direction input. The count wraps modulo 256 in both directions.

The defaults assume a 100 MHz clock and give periods of 0.5 s, 1 s, 1.5 s and 2 s. Each constant equals the period in clock cycles minus one. The count output is meant to drive LEDs and a display decoder. The step pulse is also brought out so that other logic can follow the count's cadence. Switch conditioning and display decoding belong to the surrounding logic.

Top module: `rate_step_counter`

## Requirements
- R1: A `rate_sel` value of k (0 to 3) selects delay constant DLYk. By default DLYk equals (k+1)·CLK_HZ/2 − 1, which gives 0.5 s, 1 s, 1.5 s and 2 s for k = 0, 1, 2, 3.
- R2: The internal tick value rises by one per clock from zero. `step_pulse` is high in exactly the cycle in which the tick value equals the selected delay, and that edge returns the tick to zero. Consecutive pulses are therefore DLYk+1 cycles apart.
- R3: `step_pulse` is never high in two consecutive cycles, because every delay constant is at least 1.
- R4: In a cycle with `step_pulse` low, `count` keeps its value.
- R5: In a cycle with `step_pulse` high and `count_up` = 1, `count` rises by one at the clock edge that ends the cycle.
- R6: In a cycle with `step_pulse` high and `count_up` = 0, `count` falls by one at the clock edge that ends the cycle.
- R7: The count wraps: 0xFF plus one gives 0x00, and 0x00 minus one gives 0xFF.
- R8: If `rate_sel` moves to a delay below the current tick value, the next edge clears the tick to zero without a pulse. The next pulse then comes once the tick climbs to the new delay.
- R9: Driving `rst_n` low clears the count and the tick at once, with no clock edge needed. `count` reads 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Selects one of the four delay constants |
| count_up | input | 1 | Direction of a step: 1 counts up, 0 counts down |
| step_pulse | output | 1 | One-cycle pulse at each step |
| count | output | 8 | Current count value |

## Verification
The bench overrides the four delays with 3, 5, 8 and 12, which give pulse periods of 4, 6, 9 and 13 cycles. With these values, every rate can be swept in both directions in a few hundred cycles, cycle by cycle. The same setting lets a run of more than 256 steps cross the wrap point in both directions. It also lets the tick sit above a smaller newly selected delay, which exercises the over-target clear path.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   // Number of clock cycles in 'halves' half-seconds, minus one, so that the
   // tick restarting at zero gives a period of exactly that many cycles.
   function automatic int unsigned half_sec_delay(input int unsigned clk_hz,
                                                  input int unsigned halves);
      return (clk_hz * halves) / 2 - 1;
   endfunction

endpackage

// File: rtl/rsc_rate_mux.sv
module rsc_rate_mux #(
   parameter int unsigned W      = 29,
   parameter int unsigned N      = 4,
   parameter bit          AND_OR = 1'b1,
   localparam int unsigned SW    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0][W-1:0] choices,
   input  logic [SW-1:0]       sel,
   output logic [W-1:0]        y
);

   generate
      if (AND_OR) begin : g_and_or
         logic [N-1:0][W-1:0] masked;
         for (genvar i = 0; i < N; i++) begin : g_leg
            assign masked[i] = (sel == SW'(i)) ? choices[i] : '0;
         end
         always_comb begin
            y = '0;
            for (int i = 0; i < N; i++) y = y | masked[i];
         end
      end else begin : g_index
         assign y = choices[sel];
      end
   endgenerate

endmodule

// File: rtl/rsc_tick_gen.sv
module rsc_tick_gen #(
   parameter int unsigned W = 29
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] dly,
   output logic         pulse
);

   logic [W-1:0] tick_q;
   logic         over;

   assign pulse = (tick_q == dly);
   assign over  = (tick_q > dly);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tick_q <= '0;
      else if (pulse || over)  tick_q <= '0;
      else                     tick_q <= tick_q + W'(1);
   end

   // R2: a pulse restarts the tick
   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> (tick_q == '0));

   // R3: no two pulses back to back while the delay is nonzero
   a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> (!pulse || dly == '0));

   // R8: a tick above the target is dropped to zero without pulsing
   a_r8_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (over && !pulse) |=> (tick_q == '0));

endmodule

// File: rtl/rsc_step_count.sv
module rsc_step_count #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         up,
   output logic [W-1:0] count
);

   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (step)    count_q <= up ? count_q + W'(1) : count_q - W'(1);
   end

   assign count = count_q;

   // R4: no step, no change
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count_q));

   // R5: upward step
   a_r5_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up) |=> (count_q == W'($past(count_q) + W'(1))));

   // R6: downward step
   a_r6_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !up) |=> (count_q == W'($past(count_q) - W'(1))));

   // R7: wrap at both ends
   a_r7_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up && count_q == '1) |=> (count_q == '0));
   a_r7_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !up && count_q == '0) |=> (count_q == '1));

endmodule

// File: rtl/rate_step_counter.sv
module rate_step_counter #(
   parameter int unsigned CLK_HZ = 100_000_000,
   parameter int unsigned TICK_W = 29,
   parameter int unsigned CNT_W  = 8,
   parameter bit          AND_OR_MUX = 1'b1,
   parameter int unsigned DLY0 = rsc_pkg::half_sec_delay(CLK_HZ, 1),
   parameter int unsigned DLY1 = rsc_pkg::half_sec_delay(CLK_HZ, 2),
   parameter int unsigned DLY2 = rsc_pkg::half_sec_delay(CLK_HZ, 3),
   parameter int unsigned DLY3 = rsc_pkg::half_sec_delay(CLK_HZ, 4)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       rate_sel,
   input  logic             count_up,
   output logic             step_pulse,
   output logic [CNT_W-1:0] count
);

   localparam int unsigned NUM_RATES = 4;
   localparam int unsigned DLY_ALL [NUM_RATES] = '{DLY0, DLY1, DLY2, DLY3};

   // Elaboration-time parameter checks
   generate
      for (genvar k = 0; k < NUM_RATES; k++) begin : g_chk
         if (DLY_ALL[k] == 0) begin : g_zero
            $error("rate_step_counter: delay %0d must be at least 1", k);
         end
         if ((64'(DLY_ALL[k]) >> TICK_W) != 0) begin : g_wide
            $error("rate_step_counter: delay %0d does not fit TICK_W", k);
         end
      end
      if (CNT_W < 1 || TICK_W < 2 || TICK_W > 32) begin : g_width
         $error("rate_step_counter: width parameter out of range");
      end
   endgenerate

   logic [NUM_RATES-1:0][TICK_W-1:0] choices;
   logic [TICK_W-1:0]                dly_sel;

   generate
      for (genvar k = 0; k < NUM_RATES; k++) begin : g_tab
         assign choices[k] = TICK_W'(DLY_ALL[k]);
      end
   endgenerate

   rsc_rate_mux #(
      .W      (TICK_W),
      .N      (NUM_RATES),
      .AND_OR (AND_OR_MUX)
   ) u_mux (
      .choices (choices),
      .sel     (rate_sel),
      .y       (dly_sel)
   );

   rsc_tick_gen #(
      .W (TICK_W)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .dly   (dly_sel),
      .pulse (step_pulse)
   );

   rsc_step_count #(
      .W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step_pulse),
      .up    (count_up),
      .count (count)
   );

   // R1: the selected delay tracks the select input
   a_r1_select: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_sel == choices[rate_sel]));

endmodule

// File: tb/rate_step_counter_tb_top.sv
module rate_step_counter_tb_top;

   localparam int D0 = 3, D1 = 5, D2 = 8, D3 = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [1:0] rate_sel = 2'd0;
   logic       count_up = 1'b1;
   logic       step_pulse;
   logic [7:0] count;

   int checks = 0;
   int failures = 0;
   int dl [4] = '{D0, D1, D2, D3};

   // bench model state
   int    mt = 0;
   int    mc = 0;
   bit    prev_p = 0;
   bit    over_prev = 0;
   string cnt_tag = "R9";

   always #10 clk = ~clk;

   rate_step_counter #(
      .DLY0 (D0), .DLY1 (D1), .DLY2 (D2), .DLY3 (D3)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_sel   (rate_sel),
      .count_up   (count_up),
      .step_pulse (step_pulse),
      .count      (count)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Runs n cycles; entered just after a falling edge.
   task automatic run(input int s, input bit u, input int n);
      for (int k = 0; k < n; k++) begin
         int    d;
         bit    exp_p;
         string ptag;
         rate_sel = 2'(s);
         count_up = u;
         #1;
         d     = dl[s];
         exp_p = (mt == d);
         ptag  = over_prev ? "R8" : (prev_p ? "R3" : "R1/R2");
         chk(ptag, int'(step_pulse), int'(exp_p));
         chk(cnt_tag, int'(count), mc);
         over_prev = 0;
         if (exp_p) begin
            if (u) cnt_tag = (mc == 255) ? "R7" : "R5";
            else   cnt_tag = (mc == 0)   ? "R7" : "R6";
            mc = u ? (mc + 1) % 256 : (mc + 255) % 256;
            mt = 0;
         end else begin
            cnt_tag = "R4";
            if (mt > d) begin
               mt = 0;
               over_prev = 1;
            end else begin
               mt = mt + 1;
            end
         end
         prev_p = exp_p;
         @(negedge clk);
      end
   endtask

   // Tick the model until its tick value reaches 'target' under select s.
   task automatic run_until_tick(input int s, input bit u, input int target);
      while (mt != target) run(s, u, 1);
   endtask

   // Reset asserted between clock edges; entered just after a falling edge.
   task automatic mid_reset();
      #5 rst_n = 1'b0;
      #2;
      chk("R9", int'(count), 0);
      chk("R9", int'(step_pulse), 0);
      @(negedge clk);
      rst_n = 1'b1;
      mt = 0; mc = 0; prev_p = 0; over_prev = 0; cnt_tag = "R9";
   endtask

   initial begin
      #3 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", int'(count), 0);
      chk("R9", int'(step_pulse), 0);
      rst_n = 1'b1;

      // R1 R2 R5: each rate upward, then downward (R6)
      for (int s = 0; s < 4; s++) begin
         run(s, 1'b1, 3 * (dl[s] + 1) + 2);
         run(s, 1'b0, 2 * (dl[s] + 1) + 1);
      end

      // R8: sit above a smaller delay, then switch down
      run_until_tick(3, 1'b1, 10);
      run(0, 1'b1, 12);
      run_until_tick(2, 1'b0, 7);
      run(1, 1'b0, 14);

      // R7: down from zero after reset, then up across the top
      mid_reset();
      run(0, 1'b0, 2 * (D0 + 1));
      run(0, 1'b1, 260 * (D0 + 1));
      run(0, 1'b0, 4 * (D0 + 1));

      // mixed direction toggling every cycle at each rate
      for (int s = 0; s < 4; s++) begin
         for (int k = 0; k < 3 * (dl[s] + 1); k++) run(s, 1'(k % 2), 1);
      end

      // R9: reset mid-count
      run(2, 1'b1, 25);
      mid_reset();
      run(1, 1'b1, 20);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule